// File: doc/BRIEF.md
# Completion Interrupt Coalescing Counter

This block sits beside one instruction queue and tracks how many finished instructions asked software for a completion interrupt. It does not raise one interrupt per completion. It holds the interrupt back until enough results have built up, or until a hold-off time has run out since the last acknowledge. Either threshold is enough to raise the interrupt.

Software configures two thresholds: a completion count and a time value, where the time value is scaled by 1024 tick pulses. It switches the interrupt on and off through separate set and clear enable registers. Software acknowledges serviced results by writing how many it has consumed. The pending count and the hold-off timer are both visible at the ports, so the system bus logic can return them on reads.

The timer stays at zero while nothing is pending. Each acknowledge restarts it. After an acknowledge, the decision is made again straight away from the remaining count, so results that are still pending raise the interrupt again without waiting for the timer.

Top module: `cmpl_coalesce`

## Requirements
- R1: A completion pulse with its interrupt-request flag set adds one to the 20-bit done count. A completion pulse without the flag leaves the count unchanged.
- R2: Writing select code 0 (acknowledge) subtracts bits [19:0] of the write data from the done count. The current count is always visible on `done_cnt_o`.
- R3: While the done count is zero, the hold-off timer reads zero and the interrupt is low.
- R4: With the enable set, the interrupt goes high when the done count is at least the count threshold. A count threshold of zero behaves exactly like a threshold of one.
- R5: With the enable set and the count nonzero, the interrupt goes high once the timer is at least the time threshold times 1024. A time threshold of zero turns the time condition off.
- R6: A write of select code 0 (acknowledge), or of select code 1 (load the done count from data bits [19:0]), returns the timer to zero.
- R7: After an acknowledge, the condition is evaluated again at once. If the remaining count still meets the count threshold, the interrupt is high without any timer wait.
- R8: Select code 3 sets the enable when data bit 0 is 1; writing 0 there has no effect. Select code 4 clears the enable when data bit 0 is 1. While the enable is clear the interrupt stays low, but counting and timing go on.
- R9: A completion and an acknowledge in the same cycle give count + 1 − ack. An acknowledge larger than the count leaves zero.
- R10: The timer advances by one on each cycle with `tick_i` high, holds on cycles without it, and saturates at its maximum.
- R11: Select code 2 loads the count threshold from data bits [19:0] and the time threshold from data bits [47:32]. Select codes 5 to 7 change nothing.
- R12: The interrupt is a registered level. It reflects the condition and enable state of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmpl_valid_i | input | 1 | One instruction completed this cycle |
| cmpl_irq_req_i | input | 1 | The completing instruction requested an interrupt |
| tick_i | input | 1 | Time-base pulse for the hold-off timer |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select code |
| wr_data_i | input | 64 | Register write data |
| irq_o | output | 1 | Coalesced interrupt level |
| done_cnt_o | output | 20 | Pending done count |
| tmr_o | output | 26 | Hold-off timer value |

## Verification
The assertions check the following on every cycle:
- The timer is forced to zero while the count is zero, and after every restart write.
- The timer saturates instead of wrapping.
- A flagged completion adds exactly one to the count.
- An acknowledge larger than the count leaves zero.
- The interrupt is low without the enable and whenever nothing is pending, and high whenever the count threshold is met.
- A zero write to the set-enable register changes nothing.

Only the bench scenarios can show the following:
- The 1024-tick time threshold firing at the exact timer value.
- Turning the time condition off with a zero threshold.
- The interrupt raised again after a partial acknowledge.
- Counting that goes on while the interrupt is disabled.
- Inert select codes leaving every output unchanged.

// File: rtl/cmpl_coalesce_pkg.sv
package cmpl_coalesce_pkg;

    // Register select codes on the write port
    typedef enum logic [2:0] {
        SEL_ACK   = 3'd0,
        SEL_LOAD  = 3'd1,
        SEL_WAIT  = 3'd2,
        SEL_ENSET = 3'd3,
        SEL_ENCLR = 3'd4
    } wsel_e;

endpackage

// File: rtl/cc_cfg_regs.sv
module cc_cfg_regs
    import cmpl_coalesce_pkg::*;
#(
    parameter int WDATA_W  = 64,
    parameter int NUM_W    = 20,
    parameter int TIME_W   = 16,
    parameter int TIME_LSB = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [2:0]         wr_sel_i,
    input  logic [WDATA_W-1:0] wr_data_i,
    output logic [NUM_W-1:0]   num_wait_o,
    output logic [TIME_W-1:0]  time_wait_o,
    output logic               en_o
);

    typedef struct packed {
        logic [NUM_W-1:0]  num_wait;
        logic [TIME_W-1:0] time_wait;
        logic              en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            case (wr_sel_i)
                SEL_WAIT: begin
                    cfg_d.num_wait  = wr_data_i[NUM_W-1:0];
                    cfg_d.time_wait = wr_data_i[TIME_LSB +: TIME_W];
                end
                SEL_ENSET: if (wr_data_i[0]) cfg_d.en = 1'b1;
                SEL_ENCLR: if (wr_data_i[0]) cfg_d.en = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign num_wait_o  = cfg_q.num_wait;
    assign time_wait_o = cfg_q.time_wait;
    assign en_o        = cfg_q.en;

    AST_ENSET_ZERO_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_sel_i == SEL_ENSET && !wr_data_i[0]) |=> (en_o == $past(en_o))); // R8

endmodule

// File: rtl/cc_done_counter.sv
module cc_done_counter #(
    parameter int CNT_W = 20
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inc_i,
    input  logic             ack_vld_i,
    input  logic [CNT_W-1:0] ack_val_i,
    input  logic             load_vld_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CNT_W:0] sum;
    logic [CNT_W:0] ack_ext;
    logic [CNT_W:0] diff;

    always_comb begin
        st_d    = st_q;
        sum     = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, inc_i};
        ack_ext = ack_vld_i ? {1'b0, ack_val_i} : '0;
        diff    = (ack_ext > sum) ? '0 : (sum - ack_ext);
        if (load_vld_i)   st_d.cnt = load_val_i;
        else if (diff[CNT_W]) st_d.cnt = CNT_MAX;
        else              st_d.cnt = diff[CNT_W-1:0];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    AST_INC_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && !ack_vld_i && !load_vld_i && cnt_o != CNT_MAX) |=> (cnt_o == $past(cnt_o) + 1'b1)); // R1
    AST_ACK_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_vld_i && !load_vld_i && !inc_i && ack_val_i > cnt_o) |=> (cnt_o == '0)); // R9

endmodule

// File: rtl/cc_holdoff_timer.sv
module cc_holdoff_timer #(
    parameter int TMR_W = 26
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pending_i,
    input  logic             restart_i,
    input  logic             tick_i,
    output logic [TMR_W-1:0] tmr_o
);

    localparam logic [TMR_W-1:0] TMR_MAX = '1;

    typedef struct packed {
        logic [TMR_W-1:0] tmr;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pending_i || restart_i)            st_d.tmr = '0;
        else if (tick_i && st_q.tmr != TMR_MAX) st_d.tmr = st_q.tmr + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tmr_o = st_q.tmr;

    AST_IDLE_TMR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pending_i |=> (tmr_o == '0)); // R3
    AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (tmr_o == '0)); // R6
    AST_TMR_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pending_i && !restart_i && tmr_o == TMR_MAX) |=> (tmr_o == TMR_MAX)); // R10

endmodule

// File: rtl/cmpl_coalesce.sv
module cmpl_coalesce
    import cmpl_coalesce_pkg::*;
#(
    parameter int CNT_W      = 20,
    parameter int TIME_W     = 16,
    parameter int TIME_SHIFT = 10,
    parameter int TIME_LSB   = 32,
    parameter int WDATA_W    = 64,
    localparam int TMR_W     = TIME_W + TIME_SHIFT
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cmpl_valid_i,
    input  logic               cmpl_irq_req_i,
    input  logic               tick_i,
    input  logic               wr_en_i,
    input  logic [2:0]         wr_sel_i,
    input  logic [WDATA_W-1:0] wr_data_i,
    output logic               irq_o,
    output logic [CNT_W-1:0]   done_cnt_o,
    output logic [TMR_W-1:0]   tmr_o
);

    logic [CNT_W-1:0]  num_wait;
    logic [TIME_W-1:0] time_wait;
    logic              en;
    logic              ack_vld, load_vld, inc;
    logic [CNT_W-1:0]  num_eff;
    logic [TMR_W-1:0]  time_thresh;
    logic              cond;

    typedef struct packed {
        logic irq;
    } irq_st_t;

    irq_st_t st_d, st_q;

    assign ack_vld  = wr_en_i && (wr_sel_i == SEL_ACK);
    assign load_vld = wr_en_i && (wr_sel_i == SEL_LOAD);
    assign inc      = cmpl_valid_i && cmpl_irq_req_i;

    cc_cfg_regs #(
        .WDATA_W (WDATA_W),
        .NUM_W   (CNT_W),
        .TIME_W  (TIME_W),
        .TIME_LSB(TIME_LSB)
    ) i_cfg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_sel_i   (wr_sel_i),
        .wr_data_i  (wr_data_i),
        .num_wait_o (num_wait),
        .time_wait_o(time_wait),
        .en_o       (en)
    );

    cc_done_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .inc_i     (inc),
        .ack_vld_i (ack_vld),
        .ack_val_i (wr_data_i[CNT_W-1:0]),
        .load_vld_i(load_vld),
        .load_val_i(wr_data_i[CNT_W-1:0]),
        .cnt_o     (done_cnt_o)
    );

    cc_holdoff_timer #(.TMR_W(TMR_W)) i_tmr (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .pending_i(done_cnt_o != '0),
        .restart_i(ack_vld || load_vld),
        .tick_i   (tick_i),
        .tmr_o    (tmr_o)
    );

    always_comb begin
        num_eff     = (num_wait == '0) ? CNT_W'(1) : num_wait;
        time_thresh = TMR_W'(time_wait) << TIME_SHIFT;
        cond        = (done_cnt_o != '0) &&
                      ((done_cnt_o >= num_eff) ||
                       ((time_wait != '0) && (tmr_o >= time_thresh)));
        st_d.irq    = cond && en;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en |=> !irq_o); // R8
    AST_IRQ_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_cnt_o == '0) |=> !irq_o); // R3
    AST_IRQ_ON_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en && done_cnt_o >= num_eff) |=> irq_o); // R4

endmodule

// File: tb/test_cmpl_coalesce.sv
`timescale 1ns/1ps
module test_cmpl_coalesce;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmpl_valid = 1'b0, cmpl_req = 1'b0, tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [63:0] wr_data = '0;
    logic        irq;
    logic [19:0] cnt;
    logic [25:0] tmr;
    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cmpl_coalesce i_cmpl_coalesce (
        .clk_i(clk), .rst_ni(rst_n), .cmpl_valid_i(cmpl_valid), .cmpl_irq_req_i(cmpl_req),
        .tick_i(tick), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .irq_o(irq), .done_cnt_o(cnt), .tmr_o(tmr)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic wr(input logic [2:0] sel, input logic [63:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic cmpl(input logic flag);
        cmpl_valid = 1'b1; cmpl_req = flag;
        step();
        cmpl_valid = 1'b0; cmpl_req = 1'b0;
    endtask

    function automatic logic [63:0] waitcfg(input int num, input int tw);
        return (64'(tw) << 32) | 64'(num);
    endfunction

    task automatic t_reset();
        chk("R3", "count after reset", 64'(cnt), 0);
        chk("R3", "timer after reset", 64'(tmr), 0);
        chk("R3", "irq after reset", 64'(irq), 0);
    endtask

    task automatic t_count_thresh();
        wr(3'd3, 64'd1);
        wr(3'd2, waitcfg(3, 0));
        cmpl(1'b1); cmpl(1'b1); cmpl(1'b0);
        chk("R1", "count after 2 flagged + 1 plain", 64'(cnt), 2);
        step();
        chk("R4", "irq below count threshold", 64'(irq), 0);
        cmpl(1'b1);
        chk("R1", "count 3", 64'(cnt), 3);
        chk("R12", "irq not yet registered", 64'(irq), 0);
        step();
        chk("R4", "irq at count threshold", 64'(irq), 1);
    endtask

    task automatic t_ack_refire();
        wr(3'd2, waitcfg(2, 0));
        tick = 1'b1;
        step(); step(); step();
        chk("R10", "timer running with pending work", 64'(tmr != 0), 1);
        wr(3'd0, 64'd1);
        chk("R2", "count after ack 1", 64'(cnt), 2);
        chk("R6", "timer restarted by ack", 64'(tmr), 0);
        step();
        chk("R7", "irq still high after partial ack", 64'(irq), 1);
        wr(3'd0, 64'd2);
        chk("R2", "count after ack 2", 64'(cnt), 0);
        step();
        chk("R3", "irq low when nothing pending", 64'(irq), 0);
        chk("R3", "timer held at zero", 64'(tmr), 0);
        tick = 1'b0;
    endtask

    task automatic t_num_zero();
        wr(3'd2, waitcfg(0, 0));
        cmpl(1'b1);
        step();
        chk("R4", "num threshold zero acts as one", 64'(irq), 1);
        wr(3'd0, 64'd1);
        step();
        chk("R3", "irq low after full ack", 64'(irq), 0);
    endtask

    task automatic t_time_thresh();
        logic [25:0] t0;
        wr(3'd2, waitcfg(100, 1));
        tick = 1'b1;
        cmpl(1'b1);
        chk("R3", "timer zero at first pending edge", 64'(tmr), 0);
        step();
        chk("R10", "timer one tick", 64'(tmr), 1);
        tick = 1'b0;
        t0 = tmr;
        step(); step();
        chk("R10", "timer holds without tick", 64'(tmr), 64'(t0));
        tick = 1'b1;
        for (int i = 0; i < 3000 && tmr != 26'd1024; i++) step();
        chk("R5", "timer reached 1024", 64'(tmr), 1024);
        chk("R5", "irq before time condition seen", 64'(irq), 0);
        step();
        chk("R5", "irq from time threshold", 64'(irq), 1);
        wr(3'd2, waitcfg(100, 0));
        step();
        chk("R5", "time threshold zero disables", 64'(irq), 0);
        chk("R11", "count untouched by wait write", 64'(cnt), 1);
        tick = 1'b0;
    endtask

    task automatic t_load();
        tick = 1'b1;
        wr(3'd1, 64'd5);
        tick = 1'b0;
        chk("R6", "count loaded", 64'(cnt), 5);
        chk("R6", "timer restarted by load", 64'(tmr), 0);
        wr(3'd2, waitcfg(5, 0));
        step();
        chk("R11", "new count threshold applied", 64'(irq), 1);
    endtask

    task automatic t_enable();
        wr(3'd4, 64'd1);
        step();
        chk("R8", "irq low after enable clear", 64'(irq), 0);
        cmpl(1'b1);
        chk("R8", "counting continues while disabled", 64'(cnt), 6);
        wr(3'd3, 64'd0);
        step();
        chk("R8", "zero write to set has no effect", 64'(irq), 0);
        wr(3'd3, 64'd1);
        step();
        chk("R8", "irq back after enable set", 64'(irq), 1);
    endtask

    task automatic t_simul();
        cmpl_valid = 1'b1; cmpl_req = 1'b1;
        wr(3'd0, 64'd3);
        cmpl_valid = 1'b0; cmpl_req = 1'b0;
        chk("R9", "net of inc and ack", 64'(cnt), 4);
        wr(3'd0, 64'd10);
        chk("R9", "oversized ack floors at zero", 64'(cnt), 0);
    endtask

    task automatic t_inert_sel();
        wr(3'd1, 64'd7);
        step();
        wr(3'd6, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(3'd5, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(3'd7, 64'd0);
        chk("R11", "count unchanged by inert selects", 64'(cnt), 7);
        step();
        chk("R11", "irq unchanged by inert selects", 64'(irq), 1);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_count_thresh();
        t_ack_refire();
        t_num_zero();
        t_time_thresh();
        t_load();
        t_enable();
        t_simul();
        t_inert_sel();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule